// File: doc/BRIEF.md
# Four-Beat Burst Offset Sequencer

This block generates the low-order word offset used during a four-beat cache line burst. When a new access starts, it captures the starting offset and the burst ordering. Each later advance request then moves it one beat further through the burst. It drives the current two-bit offset on every cycle. It also raises a flag while the final beat of the burst is being presented.

Two orderings are supported. The interleaved order flips offset bits by XOR-ing the starting offset with the beat number. The linear order adds the beat number to the starting offset and wraps modulo four. Any of the four offsets may be the starting point. The surrounding address path combines the output with the upper address bits, which it holds itself.

Top module: `burst_addr_ctr`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `offset_o` is 0 and `last_o` is 0.
- R2: When `load_i` is high at a rising edge, from the next cycle `offset_o` equals the `start_i` sampled at that edge, and `last_o` is 0. That beat is beat 0.
- R3: When both `load_i` and `adv_i` are low at an edge, `offset_o` and `last_o` keep their values.
- R4: If `mode_i` was 0 at the load, beat k presents `offset_o` = start XOR k. This is the interleaved order; for example, start 1 gives 1, 0, 3, 2.
- R5: If `mode_i` was 1 at the load, beat k presents `offset_o` = (start + k) mod 4. This is the linear order; for example, start 1 gives 1, 2, 3, 0.
- R6: `mode_i` is sampled only at a load. A change of `mode_i` during a burst does not affect `offset_o`.
- R7: When `load_i` and `adv_i` are both high at an edge, the load wins and the next beat is beat 0.
- R8: `last_o` is high exactly while the beat number is 3, which means three advances have occurred since the load.
- R9: An advance taken on beat 3 wraps the burst to beat 0. `offset_o` returns to the start value and `last_o` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Start a new burst from `start_i` |
| start_i | input | 2 | Starting offset of the burst |
| mode_i | input | 1 | Burst order: 0 interleaved, 1 linear |
| adv_i | input | 1 | Step to the next beat |
| offset_o | output | 2 | Current beat offset |
| last_o | output | 1 | High on the final beat |

## Verification
The bench uses the default offset width of 2, which gives four beats per burst. At that width every start offset in both orderings can be swept exhaustively. The sweep includes stalled cycles, a wrap past the last beat, a mode toggle in the middle of a burst, and a load that coincides with an advance. Each cycle is compared against an integer model that derives the offset from the beat number with XOR or modular addition.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {
    ORDER_INTERLEAVED = 1'b0,
    ORDER_LINEAR      = 1'b1
  } burst_order_e;

  localparam int unsigned DEFAULT_OFF_W = 2;
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int unsigned OFF_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             burst_load,
  input  logic             beat_step,
  output logic [OFF_W-1:0] beat_q,
  output logic             final_beat
);
  localparam logic [OFF_W-1:0] LAST_BEAT = {OFF_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          beat_q <= '0;
    else if (burst_load) beat_q <= '0;
    else if (beat_step)  beat_q <= beat_q + 1'b1;
  end

  assign final_beat = (beat_q == LAST_BEAT);

  // R9: stepping from the last beat wraps to beat 0
  p_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (final_beat && beat_step && !burst_load) |=> (beat_q == '0 && !final_beat));

  // R8: the last beat can only be reached through a step
  p_last_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(final_beat) |-> ($past(beat_step) && !$past(burst_load)));
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_seq_pkg::*;
#(
  parameter int unsigned OFF_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             burst_load,
  input  logic [OFF_W-1:0] start_d,
  input  logic             mode_d,
  input  logic [OFF_W-1:0] beat_q,
  output logic [OFF_W-1:0] offset
);
  logic [OFF_W-1:0] start_q;
  burst_order_e     order_q;

  function automatic logic [OFF_W-1:0] interleave_off(
    input logic [OFF_W-1:0] s, input logic [OFF_W-1:0] k);
    return s ^ k;
  endfunction

  function automatic logic [OFF_W-1:0] linear_off(
    input logic [OFF_W-1:0] s, input logic [OFF_W-1:0] k);
    return s + k;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      order_q <= ORDER_INTERLEAVED;
    end else if (burst_load) begin
      start_q <= start_d;
      order_q <= burst_order_e'(mode_d);
    end
  end

  always_comb begin
    if (order_q == ORDER_LINEAR) offset = linear_off(start_q, beat_q);
    else                         offset = interleave_off(start_q, beat_q);
  end

  // R6: the captured order changes only at a load
  p_mode_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !burst_load |=> $stable(order_q));

  // R9: beat 0 always presents the captured start offset
  p_beat0_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_q == '0) |-> (offset == start_q));
endmodule

// File: rtl/burst_addr_ctr.sv
module burst_addr_ctr
  import burst_seq_pkg::*;
#(
  parameter int unsigned OFF_W = DEFAULT_OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [OFF_W-1:0] start_i,
  input  logic             mode_i,
  input  logic             adv_i,
  output logic [OFF_W-1:0] offset_o,
  output logic             last_o
);
  logic             burst_load;
  logic             beat_step;
  logic [OFF_W-1:0] beat_q;
  logic             final_beat;

  assign burst_load = load_i;
  assign beat_step  = adv_i && !load_i;

  burst_beat_ctr #(.OFF_W(OFF_W)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .burst_load (burst_load),
    .beat_step  (beat_step),
    .beat_q     (beat_q),
    .final_beat (final_beat)
  );

  burst_order_map #(.OFF_W(OFF_W)) u_map (
    .clk        (clk),
    .rst_n      (rst_n),
    .burst_load (burst_load),
    .start_d    (start_i),
    .mode_d     (mode_i),
    .beat_q     (beat_q),
    .offset     (offset_o)
  );

  assign last_o = final_beat;

  // R2 / R7: a load presents the start offset next cycle, even with adv_i
  p_load_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (offset_o == $past(start_i) && !last_o));

  // R3: without load or advance the outputs hold
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !adv_i) |=> ($stable(offset_o) && $stable(last_o)));

  // R8: an advance from the last beat always leaves it
  p_last_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && adv_i) |=> !last_o);
endmodule

// File: tb/burst_addr_ctr_test.sv
module burst_addr_ctr_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load_i = 1'b0;
  logic [1:0] start_i = 2'd0;
  logic       mode_i = 1'b0;
  logic       adv_i = 1'b0;
  logic [1:0] offset_o;
  logic       last_o;

  int checks = 0;
  int failures = 0;
  int m_start = 0;
  int m_beat = 0;
  int m_mode = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  burst_addr_ctr uut (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .start_i(start_i),
    .mode_i(mode_i), .adv_i(adv_i), .offset_o(offset_o), .last_o(last_o)
  );

  function automatic int exp_off();
    if (m_mode == 1) return (m_start + m_beat) % 4;
    return m_start ^ m_beat;
  endfunction

  task automatic compare(input string tag);
    int eo;
    int el;
    eo = exp_off();
    el = (m_beat == 3) ? 1 : 0;
    checks++;
    if (int'(offset_o) != eo || int'(last_o) != el) begin
      failures++;
      $display("FAIL %s: offset=%0d last=%0d expected offset=%0d last=%0d",
               tag, offset_o, last_o, eo, el);
    end
  endtask

  task automatic step(input bit ld, input int st, input bit md, input bit ad,
                      input string tag);
    @(negedge clk);
    load_i = ld; start_i = st[1:0]; mode_i = md; adv_i = ad;
    @(posedge clk);
    if (ld) begin
      m_start = st; m_beat = 0; m_mode = md;
    end else if (ad) begin
      m_beat = (m_beat + 1) % 4;
    end
    #1;
    compare(tag);
  endtask

  initial begin
    #100000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1 in reset");
    rst_n = 1'b1;
    @(posedge clk); #1;
    compare("R1 after release");

    for (int md = 0; md < 2; md++) begin
      for (int s = 0; s < 4; s++) begin
        string ord;
        ord = (md == 1) ? "R5 linear" : "R4 interleaved";
        step(1'b1, s, md[0], 1'b0, "R2 load");
        step(1'b0, s, md[0], 1'b1, ord);
        step(1'b0, s, md[0], 1'b0, "R3 stall");
        step(1'b0, s, md[0], 1'b0, "R3 stall");
        step(1'b0, s, md[0], 1'b1, ord);
        step(1'b0, s, !md[0], 1'b1, "R8 last beat");
        step(1'b0, s, md[0], 1'b0, "R3 stall on last");
        step(1'b0, s, md[0], 1'b1, "R9 wrap");
        step(1'b0, s, md[0], 1'b1, ord);
      end
    end

    step(1'b1, 2, 1'b1, 1'b0, "R2 load linear");
    step(1'b0, 0, 1'b0, 1'b1, "R6 mode low mid burst");
    step(1'b0, 0, 1'b0, 1'b1, "R6 mode low mid burst");
    step(1'b0, 0, 1'b1, 1'b1, "R6 mode toggled");

    step(1'b1, 3, 1'b0, 1'b1, "R7 load beats adv");
    step(1'b0, 0, 1'b0, 1'b1, "R4 after R7");
    step(1'b0, 0, 1'b0, 1'b1, "R4 after R7");
    step(1'b1, 1, 1'b1, 1'b1, "R7 load beats adv mid burst");
    step(1'b0, 0, 1'b0, 1'b1, "R5 after R7");

    @(negedge clk);
    load_i = 1'b0; adv_i = 1'b0;
    rst_n = 1'b0;
    m_start = 0; m_beat = 0; m_mode = 0;
    #1;
    compare("R1 reset mid burst");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule